// File: doc/BRIEF.md
# STM-0 Transmit Overhead Generator

This block assembles an outgoing STM-0 frame one byte per transfer on an 8-bit stream. The frame is 9 rows of 90 bytes, sent row by row. The first 3 bytes of each row are section overhead, which the block builds itself. The other 87 bytes of each row are taken in order from a payload stream. The block writes:

- the framing bytes;
- two BIP-8 parity bytes, one over the whole previous frame and one over its line part;
- a payload pointer fixed at 522, with a new-data-flag option;
- the line indications: alarm, remote defect and remote error count.

Each of the three indications can come from receiver state or from a software value. Optional per-byte error masks corrupt the framing and parity bytes for fault insertion. A frame-synchronous scrambler can be switched on.

Frames start only when an external frame pulse is seen. After any pulse, the next byte produced is the first byte of a new frame. Both streams use valid/ready handshakes:

- **Output.** Once `tx_valid` is high, the byte and its start-of-frame mark are held until `tx_ready` accepts them.
- **Payload.** `pl_ready` is offered only when the next byte to produce is a payload byte and the output register can take it. A payload byte is consumed only when `pl_valid` and `pl_ready` are both high.
- **Stalls.** An overhead byte never waits on the payload stream. A payload slot waits for `pl_valid`.

Top module: `sts0_tx_oh_gen`

## Requirements
- R1: After reset, and until the first cycle with `frame_sync` high, `tx_valid` and `pl_ready` stay low.
- R2: Frame layout and start mark:
  - Bytes leave in row-major order over 9 rows of 90 columns.
  - Columns 3..89 carry payload bytes in the order they were accepted.
  - `tx_sof` is high exactly on row 0 column 0.
  - Overhead positions not named in another requirement carry 0x00.
- R3: In a cycle with `frame_sync` high, the next byte produced (in that cycle or later) is row 0 column 0, whatever the position reached.
- R4: Framing bytes: row 0 column 0 is 0xF6 XOR `a1_err_mask`, and row 0 column 1 is 0x28 XOR `a2_err_mask`.
- R5: First parity byte (row 1 column 0):
  - It is the XOR of every byte as it appeared on `tx_data` from the previous row 0 column 0 up to the current one, then XOR `b1_err_mask`.
  - Before any previous frame it is 0x00 XOR the mask.
- R6: Second parity byte (row 4 column 0):
  - It is the XOR of the previous frame's rows 3..8, taken before scrambling and after alarm substitution, then XOR `b2_err_mask`.
  - It is 0x00 XOR the mask before any previous frame.
- R7: Pointer bytes:
  - Row 3 column 0 is {flag nibble, 2'b00, 2'b10}. The flag nibble is 4'b1001 when `ndf_force` is high in the cycle the byte is produced, else 4'b0110.
  - Row 3 column 1 is 0x0A, so the two bytes together give a pointer of 522.
  - Row 3 column 2 is 0x00.
- R8: Scrambling:
  - `scr_en`, sampled when row 0 column 0 is produced, applies to the whole frame.
  - When set, every byte outside row 0 is XORed with a keystream. The keystream generator is 7 bits wide and starts at all ones on row 1 column 0.
  - Each keystream byte is 8 successive generator outputs, MSB first. Each step outputs bit 6, then shifts left, feeding in bit 6 XOR bit 5.
- R9: Row 4 column 2 is 0x06 while the remote defect indication is active, else 0x00.
- R10: Row 8 column 2 carries the 8-bit remote error count.
- R11: Line alarm:
  - While the alarm indication is active, every byte of rows 3..8 is 0xFF before scrambling.
  - Payload is still consumed at its usual positions.
- R12: Indication sources:
  - `ind_sw_sel` bit 0 selects the software source for the alarm, bit 1 for the remote defect, and bit 2 for the error count. Otherwise the receiver inputs are used.
  - The selected values are captured when row 0 column 0 is produced and hold for that frame.
- R13: Handshake:
  - While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_sof` hold.
  - `pl_ready` is high only when the next byte is a payload byte and the output register is empty or being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | External frame pulse, restarts the frame |
| scr_en | input | 1 | Scrambler enable, sampled per frame |
| ndf_force | input | 1 | Sets the new data flag in the pointer |
| a1_err_mask | input | 8 | Error mask for the first framing byte |
| a2_err_mask | input | 8 | Error mask for the second framing byte |
| b1_err_mask | input | 8 | Error mask for the frame parity byte |
| b2_err_mask | input | 8 | Error mask for the line parity byte |
| ind_sw_sel | input | 3 | Per-indication software source select |
| sw_ais | input | 1 | Software line alarm |
| sw_rdi | input | 1 | Software remote defect |
| sw_rei | input | 8 | Software remote error count |
| rx_ais | input | 1 | Receiver line alarm |
| rx_rdi | input | 1 | Receiver remote defect |
| rx_rei | input | 8 | Receiver remote error count |
| pl_data | input | 8 | Payload byte |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte can be taken |
| tx_data | output | 8 | Transmitted byte |
| tx_valid | output | 1 | Transmitted byte valid |
| tx_sof | output | 1 | Byte is row 0 column 0 |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The two functions that share a cycle are the frame restart and the parity bookkeeping. When `frame_sync` lands mid-frame, the truncated frame must still be closed out correctly. Its partial BIP-8 sums are latched at the forced row 0 column 0 and then inserted into the new frame. The bench pulses `frame_sync` partway through a scrambled frame, and in cycles where output stalls and payload gaps are also present. It judges the result on the very next frame's parity bytes, whose expected values are computed by a behavioural model that tracks all transmitted bytes.

// File: rtl/sts0_tx_pkg.sv
package sts0_tx_pkg;
  localparam logic [7:0] FRM_A1   = 8'hF6;
  localparam logic [7:0] FRM_A2   = 8'h28;
  localparam logic [3:0] NDF_IDLE = 4'b0110;
  localparam logic [3:0] NDF_SET  = 4'b1001;
  localparam logic [2:0] RDI_CODE = 3'b110;

  typedef struct packed {
    logic       ais;
    logic       rdi;
    logic [7:0] rei;
  } line_ind_t;

  function automatic logic [7:0] ptr_high(input logic ndf, input logic [9:0] ptr);
    return {(ndf ? NDF_SET : NDF_IDLE), 2'b00, ptr[9:8]};
  endfunction
endpackage

// File: rtl/sts0_frame_pos.sv
module sts0_frame_pos #(
  parameter int ROWS = 9,
  parameter int COLS = 90,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          restart,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  assign row_o = restart ? '0 : row_q;
  assign col_o = restart ? '0 : col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (adv) begin
      if (col_o == COL_LAST) begin
        col_q <= '0;
        row_q <= (row_o == ROW_LAST) ? '0 : row_o + 1'b1;
      end else begin
        col_q <= col_o + 1'b1;
        row_q <= row_o;
      end
    end
  end
endmodule

// File: rtl/sts0_scrambler.sv
module sts0_scrambler #(
  parameter int SW = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       seed,
  output logic [7:0] ks
);
  logic [SW-1:0] st_q, st_use, st_nxt;

  always_comb begin
    st_use = seed ? '1 : st_q;
    st_nxt = st_use;
    for (int i = 0; i < 8; i++) begin
      ks[7-i] = st_nxt[SW-1];
      st_nxt  = {st_nxt[SW-2:0], st_nxt[SW-1] ^ st_nxt[SW-2]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= '1;
    else if (adv) st_q <= st_nxt;
  end
endmodule

// File: rtl/sts0_bip8.sv
module sts0_bip8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         close,
  input  logic         add_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] bip_q
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bip_q <= '0;
    end else if (close) begin
      bip_q <= acc_q;
      acc_q <= add_en ? din : '0;
    end else if (add_en) begin
      acc_q <= acc_q ^ din;
    end
  end
endmodule

// File: rtl/sts0_tx_oh_gen.sv
module sts0_tx_oh_gen
  import sts0_tx_pkg::*;
#(
  parameter int ROWS    = 9,
  parameter int COLS    = 90,
  parameter int OH_COLS = 3,
  parameter int PTR_VAL = 522
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_sync,
  input  logic       scr_en,
  input  logic       ndf_force,
  input  logic [7:0] a1_err_mask,
  input  logic [7:0] a2_err_mask,
  input  logic [7:0] b1_err_mask,
  input  logic [7:0] b2_err_mask,
  input  logic [2:0] ind_sw_sel,
  input  logic       sw_ais,
  input  logic       sw_rdi,
  input  logic [7:0] sw_rei,
  input  logic       rx_ais,
  input  logic       rx_rdi,
  input  logic [7:0] rx_rei,
  input  logic [7:0] pl_data,
  input  logic       pl_valid,
  output logic       pl_ready,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  output logic       tx_sof,
  input  logic       tx_ready
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam logic [CW-1:0] OH_LIM  = CW'(OH_COLS);
  localparam logic [RW-1:0] ROW_B1  = RW'(1);
  localparam logic [RW-1:0] ROW_PTR = RW'(3);
  localparam logic [RW-1:0] ROW_B2  = RW'(4);
  localparam logic [RW-1:0] ROW_REI = RW'(ROWS - 1);
  localparam logic [9:0]    PTR     = 10'(PTR_VAL);

  logic          started_q, pend_q, started, pend, out_free, adv, is_oh, sof_pos;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [7:0]    raw_b, pre_b, out_b, ks, b1_q, b2_q;
  logic          scr_q, ais_zone, scr_zone;
  line_ind_t     ind_q, ind_new;

  assign started  = started_q | frame_sync;
  assign pend     = pend_q | frame_sync;
  assign out_free = !tx_valid || tx_ready;
  assign is_oh    = col < OH_LIM;
  assign adv      = started && out_free && (is_oh || pl_valid);
  assign pl_ready = started && out_free && !is_oh;
  assign sof_pos  = (row == '0) && (col == '0);

  sts0_frame_pos #(.ROWS(ROWS), .COLS(COLS)) i_pos (
    .clk(clk), .rst_n(rst_n), .adv(adv), .restart(pend), .row_o(row), .col_o(col));

  sts0_scrambler i_scr (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .seed((row == ROW_B1) && (col == '0)), .ks(ks));

  sts0_bip8 i_bip_frame (
    .clk(clk), .rst_n(rst_n), .close(adv && sof_pos),
    .add_en(adv), .din(out_b), .bip_q(b1_q));

  sts0_bip8 i_bip_line (
    .clk(clk), .rst_n(rst_n), .close(adv && sof_pos),
    .add_en(adv && (row >= ROW_PTR)), .din(pre_b), .bip_q(b2_q));

  always_comb begin
    ind_new.ais = ind_sw_sel[0] ? sw_ais : rx_ais;
    ind_new.rdi = ind_sw_sel[1] ? sw_rdi : rx_rdi;
    ind_new.rei = ind_sw_sel[2] ? sw_rei : rx_rei;
  end

  always_comb begin
    raw_b = 8'h00;
    if (!is_oh) begin
      raw_b = pl_data;
    end else if (row == '0) begin
      if (col == CW'(0))      raw_b = FRM_A1 ^ a1_err_mask;
      else if (col == CW'(1)) raw_b = FRM_A2 ^ a2_err_mask;
    end else if (row == ROW_B1) begin
      if (col == CW'(0)) raw_b = b1_q ^ b1_err_mask;
    end else if (row == ROW_PTR) begin
      if (col == CW'(0))      raw_b = ptr_high(ndf_force, PTR);
      else if (col == CW'(1)) raw_b = PTR[7:0];
    end else if (row == ROW_B2) begin
      if (col == CW'(0))      raw_b = b2_q ^ b2_err_mask;
      else if (col == CW'(2)) raw_b = {5'b0, ind_q.rdi ? RDI_CODE : 3'b000};
    end else if (row == ROW_REI) begin
      if (col == CW'(2)) raw_b = ind_q.rei;
    end
  end

  assign ais_zone = ind_q.ais && (row >= ROW_PTR);
  assign scr_zone = scr_q && (row != '0);
  assign pre_b    = ais_zone ? 8'hFF : raw_b;
  assign out_b    = scr_zone ? (pre_b ^ ks) : pre_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      pend_q    <= 1'b0;
      scr_q     <= 1'b0;
      ind_q     <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= 8'h00;
      tx_sof    <= 1'b0;
    end else begin
      started_q <= started;
      if (adv) pend_q <= 1'b0;
      else     pend_q <= pend;
      if (adv && sof_pos) begin
        scr_q <= scr_en;
        ind_q <= ind_new;
      end
      if (adv) begin
        tx_valid <= 1'b1;
        tx_data  <= out_b;
        tx_sof   <= sof_pos;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sts0_tx_oh_checker.sv
module sts0_tx_oh_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_sync,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_sof,
  input logic [7:0] tx_data,
  input logic       pl_ready
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_q <= 1'b0;
    else if (frame_sync) seen_q <= 1'b1;
  end

  a_r1_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!tx_valid && !pl_ready));

  a_r13_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sof)));

  a_r13_ready_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> (!tx_valid || tx_ready));

  a_r3_sync_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && (!tx_valid || tx_ready)) |=> (tx_valid && tx_sof));

  a_r2_sof_not_twice: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_sof && !frame_sync) |=> !tx_sof);
endmodule

bind sts0_tx_oh_gen sts0_tx_oh_checker i_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_sof(tx_sof), .tx_data(tx_data), .pl_ready(pl_ready));

// File: tb/test_sts0_tx_oh_gen.sv
`timescale 1ns/1ps
module test_sts0_tx_oh_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_sync = 0, scr_en = 0, ndf_force = 0;
  logic [7:0] a1_err_mask = 0, a2_err_mask = 0, b1_err_mask = 0, b2_err_mask = 0;
  logic [2:0] ind_sw_sel = 0;
  logic sw_ais = 0, sw_rdi = 0, rx_ais = 0, rx_rdi = 0;
  logic [7:0] sw_rei = 0, rx_rei = 0, pl_data = 0;
  logic pl_valid = 0, tx_ready = 0;
  logic pl_ready, tx_valid, tx_sof;
  logic [7:0] tx_data;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sts0_tx_oh_gen i_sts0_tx_oh_gen (.*);

  // keystream bits from the stated generator rule
  bit seqb [0:126];
  initial begin
    int s;
    s = 127;
    for (int n = 0; n < 127; n++) begin
      seqb[n] = bit'((s >> 6) & 1);
      s = ((s << 1) | (((s >> 6) ^ (s >> 5)) & 1)) & 127;
    end
  end

  // behavioural model
  bit m_started, m_pend, m_valid, m_sof, m_scr, m_ais, m_rdi;
  int m_row, m_col, kidx;
  bit [7:0] m_data, m_rei, b1acc, b1q, b2acc, b2q;
  string m_tag;

  function automatic bit [7:0] ks_byte(int k);
    bit [7:0] b;
    for (int i = 0; i < 8; i++) b[7-i] = seqb[(k * 8 + i) % 127];
    return b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_started = 0; m_pend = 0; m_valid = 0; m_sof = 0; m_scr = 0;
      m_ais = 0; m_rdi = 0; m_rei = 0; m_row = 0; m_col = 0; kidx = 0;
      b1acc = 0; b1q = 0; b2acc = 0; b2q = 0; m_data = 0; m_tag = "R1";
    end else begin
      bit st, pd, adv;
      int r, c;
      bit [7:0] pre, outb;
      string tg;
      st = m_started || frame_sync;
      pd = m_pend || frame_sync;
      r = pd ? 0 : m_row;
      c = pd ? 0 : m_col;
      adv = st && (!m_valid || tx_ready) && (c < 3 || pl_valid);
      if (adv) begin
        pre = 8'h00; tg = "R2/R8";
        if (c >= 3) pre = pl_data;
        else if (r == 0 && c == 0) begin pre = 8'hF6 ^ a1_err_mask; tg = "R4"; end
        else if (r == 0 && c == 1) begin pre = 8'h28 ^ a2_err_mask; tg = "R4"; end
        else if (r == 1 && c == 0) begin pre = b1q ^ b1_err_mask; tg = "R5/R8"; end
        else if (r == 3 && c == 0) begin pre = ndf_force ? 8'h92 : 8'h62; tg = "R7/R8"; end
        else if (r == 3 && c == 1) begin pre = 8'h0A; tg = "R7/R8"; end
        else if (r == 4 && c == 0) begin pre = b2q ^ b2_err_mask; tg = "R6/R8"; end
        else if (r == 4 && c == 2) begin pre = m_rdi ? 8'h06 : 8'h00; tg = "R9/R12"; end
        else if (r == 8 && c == 2) begin pre = m_rei; tg = "R10/R12"; end
        if (m_ais && r >= 3) begin pre = 8'hFF; tg = "R11/R12"; end
        if (r == 1 && c == 0) kidx = 0;
        outb = (m_scr && r != 0) ? (pre ^ ks_byte(kidx)) : pre;
        kidx++;
        if (r == 0 && c == 0) begin
          b1q = b1acc; b1acc = outb; b2q = b2acc; b2acc = 0;
          m_scr = scr_en;
          m_ais = ind_sw_sel[0] ? sw_ais : rx_ais;
          m_rdi = ind_sw_sel[1] ? sw_rdi : rx_rdi;
          m_rei = ind_sw_sel[2] ? sw_rei : rx_rei;
        end else begin
          b1acc ^= outb;
          if (r >= 3) b2acc ^= pre;
        end
        m_data = outb; m_sof = (r == 0 && c == 0); m_tag = tg; m_valid = 1;
        c++;
        if (c == 90) begin c = 0; r = (r == 8) ? 0 : r + 1; end
        m_row = r; m_col = c; m_pend = 0;
      end else begin
        m_pend = pd;
        if (tx_ready) m_valid = 0;
      end
      m_started = st;
    end
  end

  // payload source: incrementing bytes
  always @(posedge clk) if (pl_valid && pl_ready) pl_data <= pl_data + 8'd1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_ready();
    int c;
    c = (m_pend || frame_sync) ? 0 : m_col;
    return (m_started || frame_sync) && (!m_valid || tx_ready) && c >= 3;
  endfunction

  int rnd = 32'h1234567;
  bit rand_mode = 0;

  task automatic run(int n, bit sync_first);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_sync = sync_first && i == 0;
      if (rand_mode) begin
        rnd = rnd * 1103515245 + 12345;
        tx_ready = rnd[20] | rnd[21];
        pl_valid = rnd[22] | rnd[23];
      end else begin
        tx_ready = 1; pl_valid = 1;
      end
      #2;
      chk(tx_valid == m_valid, m_started ? "R13" : "R1", tx_valid, m_valid);
      chk(pl_ready == exp_ready(), m_started ? "R13" : "R1", pl_ready, exp_ready());
      if (m_valid) begin
        chk(tx_data == m_data, m_tag, tx_data, m_data);
        chk(tx_sof == m_sof, "R2/R3", tx_sof, m_sof);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_valid == 0 && pl_ready == 0, "R1", {tx_valid, pl_ready}, 0);
    rst_n = 1;
    run(40, 0);                               // R1: no pulse yet
    run(2500, 1);                             // R2 R4 R5 R6 R7 plain frames
    a1_err_mask = 8'h01; a2_err_mask = 8'h80; b1_err_mask = 8'h11; b2_err_mask = 8'h22;
    ndf_force = 1; ind_sw_sel = 3'b110; sw_rdi = 1; sw_rei = 8'h5A;
    rx_rdi = 0; rx_rei = 8'hC3; rx_ais = 0;
    run(1700, 0);                             // R4-R7 masks/NDF, R12 software source
    a1_err_mask = 0; a2_err_mask = 0; b1_err_mask = 0; b2_err_mask = 0; ndf_force = 0;
    ind_sw_sel = 3'b000; rx_ais = 1; rx_rdi = 1; rx_rei = 8'h33; sw_ais = 0;
    scr_en = 1; rand_mode = 1;
    run(6000, 0);                             // R8 R11 R12 R13 under stalls
    rx_ais = 0; ind_sw_sel = 3'b001; sw_ais = 1;
    run(2000, 0);                             // R11 via software source
    sw_ais = 0;
    run(500, 0);
    run(2600, 1);                             // R3 mid-frame restart with parity
    rand_mode = 0;
    run(1200, 1);
    run(1000, 0);
    finish_run();
  end
endmodule